// File: doc/BRIEF.md
# Quaternary Line Maintenance Pattern Generator

This block sits in front of a four-level line transmitter and, during maintenance, replaces the normal symbol stream with a fixed test stimulus. It issues exactly one quaternary symbol (+3, +1, −1, −3, or 0 for silence) on each baud strobe. Software selects a stimulus by writing a 16-bit command word. The choices are: a lone pulse of magnitude 3 or 1 at the start of every frame, with the sign flipping from frame to frame; a continuous stream of pseudo-random sign symbols of magnitude 1 or 3; or silence.

A separate tone enable produces a square wave of +1 and −1 levels whose period is two frames, about 333 Hz at 80 kbaud. The tone is honoured only while the transceiver is powered and not activated. While the transceiver is unpowered, the output is silent and command writes are discarded.

Command changes are deferred to the next frame boundary, so a running pattern never leaves a frame half-formed. Symbol counting, the frame position and the scrambler all run from reset, whether or not a pattern is selected.

Top module: `q4_maint_patgen`

## Requirements
- R1: After reset, sym_out is 0, the next symbol is symbol 0 of a frame, no pattern is selected, and strobes with no command give 0.
- R2: sym_out changes only at a clock edge where baud_stb is high, and holds its value otherwise. It is 3-bit two's complement: +3=011, +1=001, 0=000, −1=111, −3=101.
- R3: Command 0x1001 selects lone pulses of magnitude 3. The pulse is placed on symbol 0 of each FRAME_LEN-symbol frame (default 120), and every other symbol is 0.
- R4: Command 0x1003 selects lone pulses of magnitude 1, with the same placement as R3.
- R5: Lone pulses alternate in sign from one frame to the next. The first pulse after entering a pulse mode is positive. Rewriting the code that is already active does not restart the alternation.
- R6: Command 0x1004 selects scrambled symbols of magnitude 1. The scrambler is a 23-bit register seeded to 0x1A2B3C at reset. It steps on every strobe: the new bit is bit 22 XOR bit 4, shifted into bit 0. The sign of each symbol comes from bit 22 before the step (1 means negative).
- R7: Command 0x1008 selects scrambled symbols of magnitude 3, using the sign rule of R6.
- R8: Command 0x1000 returns the output to 0 from the next frame boundary. Any other command word is ignored and leaves the selected pattern unchanged.
- R9: A command takes effect at the first symbol 0 that is emitted after the write. A write in the same cycle as the strobe for symbol 0 waits for the following frame.
- R10: With tone_en high, powered high and activated low, the output is +1 for TONE_HALF symbols and then −1 for TONE_HALF symbols (default 120), repeating. The tone begins at +1 on the first strobe after it becomes enabled, overrides any command pattern, and leaves that pattern's frame timing running underneath.
- R11: With activated high, the tone is suppressed. With powered low, the output is 0, the selected and pending patterns are cleared, and command writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_stb | input | 1 | One-cycle strobe per transmitted symbol |
| cmd_wr | input | 1 | Command word write enable |
| cmd_word | input | 16 | Maintenance command word |
| tone_en | input | 1 | Square-wave tone enable |
| powered | input | 1 | Transceiver is powered up |
| activated | input | 1 | Line is activated |
| sym_out | output | 3 | Quaternary symbol, two's complement |

## Verification
Two collisions matter for this block. In the first, a command write lands in the same cycle as the strobe for symbol 0. The bench drives both in one cycle and expects the old pattern to carry on for one more full frame, with the new one arriving only at the following boundary. In the second, the tone is enabled while a lone-pulse pattern is running. The bench expects the tone to override from the next strobe, and expects the pulse pattern to resume on schedule, with its sign sequence intact, once the transceiver is marked activated.

// File: rtl/q4_pkg.sv
package q4_pkg;

   typedef enum logic [2:0] {
      MD_OFF  = 3'd0,
      MD_ISO3 = 3'd1,
      MD_ISO1 = 3'd2,
      MD_SCR1 = 3'd3,
      MD_SCR3 = 3'd4
   } q4_mode_e;

   localparam int Q4_SYM_W = 3;

   localparam logic signed [Q4_SYM_W-1:0] Q4_P3 = 3'sd3;
   localparam logic signed [Q4_SYM_W-1:0] Q4_P1 = 3'sd1;
   localparam logic signed [Q4_SYM_W-1:0] Q4_Z0 = 3'sd0;
   localparam logic signed [Q4_SYM_W-1:0] Q4_N1 = -3'sd1;
   localparam logic signed [Q4_SYM_W-1:0] Q4_N3 = -3'sd3;

   // Signed quaternary level from a sign flag and a magnitude flag
   function automatic logic signed [Q4_SYM_W-1:0] q4_level(input logic neg, input logic big);
      if (big) return neg ? Q4_N3 : Q4_P3;
      else     return neg ? Q4_N1 : Q4_P1;
   endfunction

endpackage

// File: rtl/q4_cmd_dec.sv
module q4_cmd_dec
   import q4_pkg::*;
#(
   parameter int          CMD_W     = 16,
   parameter logic [15:0] CODE_STOP = 16'h1000,
   parameter logic [15:0] CODE_ISO3 = 16'h1001,
   parameter logic [15:0] CODE_ISO1 = 16'h1003,
   parameter logic [15:0] CODE_SCR1 = 16'h1004,
   parameter logic [15:0] CODE_SCR3 = 16'h1008
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_word,
   input  logic             powered,
   output q4_mode_e         pend
);

   generate
      if (CMD_W != 16) begin : g_bad_w
         $error("q4_cmd_dec: command width must be 16");
      end
   endgenerate

   logic     hit;
   q4_mode_e dec;

   always_comb begin
      hit = 1'b1;
      dec = MD_OFF;
      case (cmd_word)
         CODE_STOP: dec = MD_OFF;
         CODE_ISO3: dec = MD_ISO3;
         CODE_ISO1: dec = MD_ISO1;
         CODE_SCR1: dec = MD_SCR1;
         CODE_SCR3: dec = MD_SCR3;
         default:   hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pend <= MD_OFF;
      else if (!powered)          pend <= MD_OFF;
      else if (cmd_wr && hit)     pend <= dec;
   end

   // R8: an unknown word leaves the pending selection untouched
   a_r8_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (powered && cmd_wr && !hit) |=> $stable(pend));

endmodule

// File: rtl/q4_sym_counter.sv
module q4_sym_counter #(
   parameter int FRAME_LEN = 120,
   localparam int IDX_W    = $clog2(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_stb,
   output logic [IDX_W-1:0] idx,
   output logic             at_start
);

   generate
      if (FRAME_LEN < 2) begin : g_bad_len
         $error("q4_sym_counter: frame must hold at least two symbols");
      end
   endgenerate

   localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             idx <= '0;
      else if (baud_stb)      idx <= (idx == LAST) ? '0 : idx + 1'b1;
   end

   assign at_start = (idx == '0);

   // R3: the symbol position never leaves the frame
   a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST);

endmodule

// File: rtl/q4_prbs.sv
module q4_prbs #(
   parameter int             LFSR_W = 23,
   parameter int             TAP    = 5,
   parameter logic [LFSR_W-1:0] SEED = 23'h1A2B3C
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic sign_bit
);

   generate
      if (TAP < 1 || TAP >= LFSR_W) begin : g_bad_tap
         $error("q4_prbs: tap must lie inside the register");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("q4_prbs: seed must be nonzero");
      end
   endgenerate

   logic [LFSR_W-1:0] st;
   logic              fb;

   // Taps at x^LFSR_W and x^TAP map to bits LFSR_W-1 and TAP-1
   assign fb       = st[LFSR_W-1] ^ st[TAP-1];
   assign sign_bit = st[LFSR_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st <= SEED;
      else if (step)  st <= {st[LFSR_W-2:0], fb};
   end

   // R6: the scrambler never locks up in the all-zero state
   a_r6_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      st != '0);

endmodule

// File: rtl/q4_tone.sv
module q4_tone #(
   parameter int TONE_HALF = 120,
   localparam int CNT_W    = $clog2(2 * TONE_HALF)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic baud_stb,
   input  logic tone_on,
   output logic level_pos
);

   generate
      if (TONE_HALF < 1) begin : g_bad_half
         $error("q4_tone: half period must be at least one symbol");
      end
   endgenerate

   localparam logic [CNT_W-1:0] LAST = CNT_W'(2 * TONE_HALF - 1);
   localparam logic [CNT_W-1:0] HALF = CNT_W'(TONE_HALF);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!tone_on)      cnt <= '0;
      else if (baud_stb)      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   assign level_pos = (cnt < HALF);

   // R10: phase restarts from the positive half whenever the tone is off
   a_r10_restart_pos: assert property (@(posedge clk) disable iff (!rst_n)
      !tone_on |=> level_pos);

endmodule

// File: rtl/q4_maint_patgen.sv
module q4_maint_patgen
   import q4_pkg::*;
#(
   parameter int             FRAME_LEN = 120,
   parameter int             TONE_HALF = 120,
   parameter int             LFSR_W    = 23,
   parameter int             LFSR_TAP  = 5,
   parameter logic [22:0]    LFSR_SEED = 23'h1A2B3C
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        baud_stb,
   input  logic                        cmd_wr,
   input  logic [15:0]                 cmd_word,
   input  logic                        tone_en,
   input  logic                        powered,
   input  logic                        activated,
   output logic signed [Q4_SYM_W-1:0]  sym_out
);

   localparam int IDX_W = $clog2(FRAME_LEN);

   generate
      if (LFSR_W != 23) begin : g_bad_lfsr
         $error("q4_maint_patgen: seed parameter is sized for a 23-bit scrambler");
      end
   endgenerate

   q4_mode_e           pend, act, eff_mode;
   logic [IDX_W-1:0]   idx;
   logic               at_start, prbs_sign, tone_pos, tone_on;
   logic               pulse_neg, cur_neg, fresh, is_iso;
   logic signed [Q4_SYM_W-1:0] cmd_sym, next_sym;

   assign tone_on = tone_en && powered && !activated;

   q4_cmd_dec u_dec (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
      .powered(powered), .pend(pend));

   q4_sym_counter #(.FRAME_LEN(FRAME_LEN)) u_cnt (
      .clk(clk), .rst_n(rst_n), .baud_stb(baud_stb), .idx(idx), .at_start(at_start));

   q4_prbs #(.LFSR_W(LFSR_W), .TAP(LFSR_TAP), .SEED(LFSR_SEED)) u_prbs (
      .clk(clk), .rst_n(rst_n), .step(baud_stb), .sign_bit(prbs_sign));

   q4_tone #(.TONE_HALF(TONE_HALF)) u_tone (
      .clk(clk), .rst_n(rst_n), .baud_stb(baud_stb), .tone_on(tone_on), .level_pos(tone_pos));

   // Mode switch happens only on the strobe for symbol 0
   always_comb begin
      eff_mode = at_start ? pend : act;
      fresh    = at_start && (pend != act);
      cur_neg  = fresh ? 1'b0 : pulse_neg;
      is_iso   = (eff_mode == MD_ISO3) || (eff_mode == MD_ISO1);
      case (eff_mode)
         MD_ISO3: cmd_sym = at_start ? q4_level(cur_neg, 1'b1) : Q4_Z0;
         MD_ISO1: cmd_sym = at_start ? q4_level(cur_neg, 1'b0) : Q4_Z0;
         MD_SCR1: cmd_sym = q4_level(prbs_sign, 1'b0);
         MD_SCR3: cmd_sym = q4_level(prbs_sign, 1'b1);
         default: cmd_sym = Q4_Z0;
      endcase
      if (!powered)     next_sym = Q4_Z0;
      else if (tone_on) next_sym = q4_level(!tone_pos, 1'b0);
      else              next_sym = cmd_sym;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act       <= MD_OFF;
         pulse_neg <= 1'b0;
         sym_out   <= Q4_Z0;
      end else if (!powered) begin
         act       <= MD_OFF;
         pulse_neg <= 1'b0;
         if (baud_stb) sym_out <= Q4_Z0;
      end else if (baud_stb) begin
         sym_out <= next_sym;
         if (at_start) act <= pend;
         if (is_iso && at_start) pulse_neg <= ~cur_neg;
      end
   end

   // R2: only the legal quaternary codes appear
   always_comb begin
      if (rst_n) begin
         a_r2_legal_code: assert (sym_out != 3'sb100 && sym_out != 3'sb010 && sym_out != 3'sb110);
      end
   end

   // R2: output holds between strobes
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_stb |=> $stable(sym_out));

   // R11: unpowered strobes give silence
   a_r11_unpowered_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_stb && !powered) |=> (sym_out == Q4_Z0));

   // R3: lone-pulse modes are silent away from symbol 0
   a_r3_iso_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_stb && powered && !tone_on && is_iso && !at_start) |=> (sym_out == Q4_Z0));

   // R6: scrambled unit mode emits magnitude 1 only
   a_r6_scr_unit: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_stb && powered && !tone_on && eff_mode == MD_SCR1) |=>
      (sym_out == Q4_P1 || sym_out == Q4_N1));

   // R10: tone emits only +1 and -1
   a_r10_tone_unit: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_stb && tone_on) |=> (sym_out == Q4_P1 || sym_out == Q4_N1));

endmodule

// File: tb/q4_maint_patgen_bench.sv
module q4_maint_patgen_bench;

   localparam int FRAME = 120;
   localparam int HALF  = 120;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_stb = 1'b0;
   logic cmd_wr = 1'b0;
   logic [15:0] cmd_word = 16'h0;
   logic tone_en = 1'b0;
   logic powered = 1'b1;
   logic activated = 1'b0;
   logic signed [2:0] sym_out;

   always #2 clk = ~clk;

   q4_maint_patgen u_q4_maint_patgen (
      .clk(clk), .rst_n(rst_n), .baud_stb(baud_stb), .cmd_wr(cmd_wr),
      .cmd_word(cmd_word), .tone_en(tone_en), .powered(powered),
      .activated(activated), .sym_out(sym_out));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Bench-side expectation state (modes: 0 off, 1 iso3, 2 iso1, 3 scr1, 4 scr3)
   int          m_idx = 0, m_act = 0, m_pend = 0, m_tcnt = 0;
   bit          m_neg = 0;
   logic [22:0] m_lfsr = 23'h1A2B3C;

   typedef struct packed {
      logic [15:0] cmd;
      logic [1:0]  mag;
   } tv_t;

   localparam tv_t TV [6] = '{
      '{cmd: 16'h1001, mag: 2'd3},
      '{cmd: 16'h1003, mag: 2'd1},
      '{cmd: 16'h1004, mag: 2'd1},
      '{cmd: 16'h1008, mag: 2'd3},
      '{cmd: 16'h7777, mag: 2'd3},
      '{cmd: 16'h1000, mag: 2'd0}
   };

   function automatic string tv_tag(int i);
      case (i)
         0: return "R3";
         1: return "R4";
         2: return "R6";
         3: return "R7";
         default: return "R8";
      endcase
   endfunction

   function automatic int decode(logic [15:0] w);
      case (w)
         16'h1000: return 0;
         16'h1001: return 1;
         16'h1003: return 2;
         16'h1004: return 3;
         16'h1008: return 4;
         default:  return -1;
      endcase
   endfunction

   function automatic logic signed [2:0] lvl(bit neg, bit big);
      if (big) return neg ? -3'sd3 : 3'sd3;
      return neg ? -3'sd1 : 3'sd1;
   endfunction

   task automatic check(string tag, logic signed [2:0] got, logic signed [2:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic apply_cmd(logic [15:0] w);
      int d = decode(w);
      if (powered && d >= 0) m_pend = d;
   endtask

   task automatic tone_sync();
      if (!(tone_en && powered && !activated)) m_tcnt = 0;
   endtask

   // Expected symbol for the next strobe; advances bench state
   task automatic predict(output logic signed [2:0] exp);
      bit ton = tone_en && powered && !activated;
      bit fs = (m_idx == 0);
      int eff;
      bit cneg;
      logic signed [2:0] csym;
      if (!powered) exp = 3'sd0;
      else begin
         eff  = fs ? m_pend : m_act;
         cneg = (fs && m_pend != m_act) ? 1'b0 : m_neg;
         case (eff)
            1: csym = fs ? lvl(cneg, 1) : 3'sd0;
            2: csym = fs ? lvl(cneg, 0) : 3'sd0;
            3: csym = lvl(m_lfsr[22], 0);
            4: csym = lvl(m_lfsr[22], 1);
            default: csym = 3'sd0;
         endcase
         if ((eff == 1 || eff == 2) && fs) m_neg = !cneg;
         if (fs) m_act = m_pend;
         exp = ton ? ((m_tcnt < HALF) ? 3'sd1 : -3'sd1) : csym;
      end
      if (ton) m_tcnt = (m_tcnt + 1) % (2 * HALF);
      m_lfsr = {m_lfsr[21:0], m_lfsr[22] ^ m_lfsr[4]};
      m_idx  = (m_idx + 1) % FRAME;
   endtask

   // One strobe, optionally with a command write in the same cycle
   task automatic step(string tag, bit with_cmd, logic [15:0] w, output logic signed [2:0] got);
      logic signed [2:0] exp;
      predict(exp);
      @(negedge clk);
      baud_stb = 1'b1;
      cmd_wr   = with_cmd;
      cmd_word = w;
      @(negedge clk);
      baud_stb = 1'b0;
      cmd_wr   = 1'b0;
      got = sym_out;
      check(tag, got, exp);
      if (with_cmd) apply_cmd(w);
      @(negedge clk);
      check("R2", sym_out, got);
   endtask

   task automatic run(string tag, int n);
      logic signed [2:0] g;
      for (int k = 0; k < n; k++) step(tag, 1'b0, 16'h0, g);
   endtask

   task automatic run_to(string tag, int pos);
      logic signed [2:0] g;
      while (m_idx != pos) step(tag, 1'b0, 16'h0, g);
   endtask

   task automatic write_cmd(logic [15:0] w);
      @(negedge clk);
      cmd_wr = 1'b1;
      cmd_word = w;
      @(negedge clk);
      cmd_wr = 1'b0;
      apply_cmd(w);
   endtask

   task automatic set_power(bit v);
      @(negedge clk);
      powered = v;
      if (!v) begin
         m_act = 0;
         m_pend = 0;
         m_neg = 0;
      end
      tone_sync();
   endtask

   initial begin : main
      logic signed [2:0] g;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", sym_out, 3'sd0);
      run("R1", 5);

      // Table of command vectors
      for (int i = 0; i < 6; i++) begin
         run_to("R9", 40);
         write_cmd(TV[i].cmd);
         run_to("R9", 0);
         step(tv_tag(i), 1'b0, 16'h0, g);
         checks++;
         if ((g < 0 ? -g : g) != 3'(TV[i].mag)) begin
            errors++;
            $display("FAIL %s got %0d expected magnitude %0d", tv_tag(i), g, TV[i].mag);
         end
         run(tv_tag(i), FRAME - 1);
      end

      // R5: sign alternation, rewrite of the same code, fresh start on a new code
      run_to("R5", 30);
      write_cmd(16'h1001);
      run_to("R5", 0);
      step("R5", 1'b0, 16'h0, g); check("R5", g, 3'sd3);
      run_to("R5", 50);
      write_cmd(16'h1001);
      run_to("R5", 0);
      step("R5", 1'b0, 16'h0, g); check("R5", g, -3'sd3);
      run_to("R5", 0);
      step("R5", 1'b0, 16'h0, g); check("R5", g, 3'sd3);
      run_to("R5", 60);
      write_cmd(16'h1003);
      run_to("R4", 0);
      step("R5", 1'b0, 16'h0, g); check("R5", g, 3'sd1);

      // R9: write in the same cycle as the symbol 0 strobe waits a frame
      run_to("R9", 0);
      step("R9", 1'b1, 16'h1004, g); check("R9", g, -3'sd1);
      run("R9", FRAME - 1);
      step("R9", 1'b0, 16'h0, g);
      run("R6", 20);

      // Back to lone pulses, then tone on top of them
      write_cmd(16'h1001);
      run_to("R3", 0);
      run("R3", 10);
      @(negedge clk); tone_en = 1'b1; tone_sync();
      step("R10", 1'b0, 16'h0, g); check("R10", g, 3'sd1);
      run("R10", HALF - 1);
      step("R10", 1'b0, 16'h0, g); check("R10", g, -3'sd1);
      run("R10", HALF - 1);
      step("R10", 1'b0, 16'h0, g); check("R10", g, 3'sd1);

      // R11: activation suppresses the tone, pulse pattern resumes
      @(negedge clk); activated = 1'b1; tone_sync();
      run("R11", 2 * FRAME);
      @(negedge clk); activated = 1'b0; tone_en = 1'b0; tone_sync();

      // R11: power down silences and discards commands
      set_power(1'b0);
      run("R11", 10);
      write_cmd(16'h1008);
      step("R11", 1'b0, 16'h0, g); check("R11", g, 3'sd0);
      set_power(1'b1);
      run("R11", 2 * FRAME);

      // R2: long gap between strobes keeps the output
      write_cmd(16'h1004);
      run_to("R6", 0);
      step("R6", 1'b0, 16'h0, g);
      repeat (7) begin
         @(negedge clk);
         check("R2", sym_out, g);
      end
      run("R6", 30);

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule